// File: doc/BRIEF.md
# DMA Address Remapping Walker

The walker turns an address issued by a device for DMA into a host physical address. Requests arrive with a 16-bit source identity. The upper byte is the bus number and the lower byte is the device/function number. The walker uses the bus number to read a root entry. That entry points to a context table, and the device/function number picks a two-word context entry inside it. The context entry holds the root of a four-level page table. The walker then walks that table one level at a time and combines the leaf frame with the untranslated 12-bit page offset.

All table reads go through one read-only memory port. The port has a single read strobe, and its data returns on the following cycle. A request either resolves to a translated address or is blocked with a reason code. Blocked requests normally also produce a one-cycle fault record that carries the reason, the source identity and the offending address. A context entry can ask for this record to be suppressed. The request is still blocked in that case. The walker handles one walk at a time behind a ready/valid handshake on the request side. It holds its response until the requester takes it.

Top module: `dma_remap_walker`

## Requirements
- R1: `reqReady` is high only while no walk is pending. After a request is accepted it stays low until the response has been taken, and `memRd` is never asserted while `reqReady` is high.
- R2: A walk reads memory in a fixed order, one read per strobe. The reads are: the root entry at `rootBase + bus*8`; the context low word at `ctxTable + devfn*16`; the context high word 8 bytes above that; and then one page entry per level at `table + index*8`. The level indices come from address bits 47:39, 38:30, 29:21 and 20:12, in that order. A successful walk makes exactly 7 reads.
- R3: On success, `rspFault` is 0 and `rspAddr` is the leaf entry's bits 51:12 followed by request address bits 11:0. `rspSnoop` equals leaf bit 11, and `rspDomain` equals context high-word bits 23:8. Different requesters with the same address use their own tables.
- R4: A root entry with bit 0 clear ends the walk with reason 7 after that single read.
- R5: A context low word with bit 0 clear ends the walk with reason 6 after two reads. This fault is always reported, whatever bit 1 of that word holds.
- R6: A present context entry whose type field (low-word bits 3:2) is nonzero ends the walk with reason 4.
- R7: The walk ends with reason 5 in either of two cases: the context high word's bits 2:0 are not 2 (the 48-bit code), or the request address has any bit above bit 47 set.
- R8: A page entry with both bit 0 (read) and bit 1 (write) clear, at any level, ends the walk with reason 1.
- R9: At any level, a write request meeting an entry with bit 1 clear ends with reason 2, and a read request meeting an entry with bit 0 clear ends with reason 3.
- R10: Every reported fault pulses `faultValid` for exactly one cycle. The pulse falls in the first cycle of `rspValid`, and the response has `rspFault` = 1. The pulse carries the reason, the source identity and the full request address.
- R11: When the context low word has bit 1 set, faults found after the context presence check still block the request (`rspFault` = 1 with its reason), but `faultValid` stays low.
- R12: While `rspValid` is high and `rspReady` is low, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rootBase | input | 52 | Byte address of the root table |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Walker can accept a request |
| reqSrcId | input | 16 | Requester identity: bus in 15:8, device/function in 7:0 |
| reqAddr | input | 64 | Device-issued address |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Requester takes the response |
| rspAddr | output | 52 | Translated host address (0 when blocked) |
| rspFault | output | 1 | Request blocked |
| rspReason | output | 4 | Reason code of a blocked request |
| rspSnoop | output | 1 | Snoop hint from the leaf entry |
| rspDomain | output | 16 | Domain identifier from the context entry |
| faultValid | output | 1 | One-cycle fault record strobe |
| faultReason | output | 4 | Reason code of the record |
| faultSrcId | output | 16 | Source identity of the record |
| faultAddr | output | 64 | Request address of the record |
| memRd | output | 1 | Table read strobe |
| memAddr | output | 52 | Byte address of the 64-bit table word |
| memData | input | 64 | Table word, valid the cycle after `memRd` |

## Verification
The assertions rely on two input contracts. Table memory must return the addressed word exactly one cycle after each read strobe. The requester must keep `rspReady` low until it has seen `rspValid`. The bench meets both. Its sparse memory model answers every strobe on the next edge, and its tasks only change `reqValid` and `rspReady` between clock edges. Each task raises `rspReady` only after the response has appeared, and some tasks delay it on purpose so that the holding behaviour is exercised. The tables are built by bench tasks from the requirement encodings alone. Each fault scenario corrupts only the entry it targets.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int BUS_W = 8;
  localparam int DF_W  = 8;
  localparam int SID_W = BUS_W + DF_W;
  localparam int RSN_W = 4;

  typedef enum logic [1:0] {
    SEL_ROOT = 2'd0,
    SEL_CLO  = 2'd1,
    SEL_CHI  = 2'd2,
    SEL_PTE  = 2'd3
  } stageSel_t;

  typedef struct packed {
    logic      ldReq;
    logic      issueRd;
    stageSel_t sel;
    logic      absorb;
    logic      commitFault;
  } walkCtl_t;

  typedef struct packed {
    logic errHit;
    logic lastLevel;
  } walkStat_t;

  localparam logic [RSN_W-1:0] RSN_PTE_ABSENT  = 4'd1;
  localparam logic [RSN_W-1:0] RSN_WRITE_RO    = 4'd2;
  localparam logic [RSN_W-1:0] RSN_READ_DENIED = 4'd3;
  localparam logic [RSN_W-1:0] RSN_BAD_TYPE    = 4'd4;
  localparam logic [RSN_W-1:0] RSN_WIDTH       = 4'd5;
  localparam logic [RSN_W-1:0] RSN_CTX_ABSENT  = 4'd6;
  localparam logic [RSN_W-1:0] RSN_ROOT_ABSENT = 4'd7;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  input  walkStat_t stat,
  output walkCtl_t  ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_RESP} walkState_t;

  walkState_t state, stateNxt;
  stageSel_t  stage, stageNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stage <= SEL_ROOT;
    end else begin
      state <= stateNxt;
      stage <= stageNxt;
    end
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    stageNxt = stage;
    reqReady = (state == ST_IDLE);
    rspValid = (state == ST_RESP);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.ldReq = 1'b1;
          stageNxt  = SEL_ROOT;
          stateNxt  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl.issueRd = 1'b1;
        ctl.sel     = stage;
        stateNxt    = ST_CHECK;
      end
      ST_CHECK: begin
        ctl.sel = stage;
        if (stat.errHit) begin
          ctl.commitFault = 1'b1;
          stateNxt        = ST_RESP;
        end else begin
          ctl.absorb = 1'b1;
          if (stage == SEL_PTE && stat.lastLevel) begin
            stateNxt = ST_RESP;
          end else begin
            stateNxt = ST_FETCH;
            if (stage != SEL_PTE) stageNxt = stageSel_t'(stage + 2'd1);
          end
        end
      end
      default: begin
        if (rspReady) stateNxt = ST_IDLE;
      end
    endcase
  end

  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R1
  AST_RESP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> reqReady && !rspValid); // R1
endmodule

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int PA_W    = 52,
  parameter int IN_W    = 64,
  parameter int GAW     = 48,
  parameter int DID_W   = 16,
  parameter int AW_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  output walkStat_t         stat,
  input  logic [SID_W-1:0]  reqSrcId,
  input  logic [IN_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [PA_W-1:0]   rootBase,
  output logic [PA_W-1:0]   memAddr,
  input  logic [63:0]       memData,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspFault,
  output logic [RSN_W-1:0]  rspReason,
  output logic              rspSnoop,
  output logic [DID_W-1:0]  rspDomain,
  output logic              faultValid,
  output logic [RSN_W-1:0]  faultReason,
  output logic [SID_W-1:0]  faultSrcId,
  output logic [IN_W-1:0]   faultAddr
);
  localparam int PAGE_SHIFT = 12;
  localparam int LVL_BITS   = 9;
  localparam int LEVELS     = (GAW - PAGE_SHIFT) / LVL_BITS;
  localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PFN_W      = PA_W - PAGE_SHIFT;
  localparam int DOM_LSB    = 8;

  logic [SID_W-1:0]  srcQ;
  logic [IN_W-1:0]   addrQ;
  logic              wrQ;
  logic [PFN_W-1:0]  ctxPtrQ;
  logic [PFN_W-1:0]  ptrQ;
  logic [LVL_W-1:0]  lvlQ;
  logic              fpdQ;
  logic [DID_W-1:0]  domQ;
  logic [PFN_W-1:0]  frameQ;
  logic              snpQ;
  logic              faultQ;
  logic [RSN_W-1:0]  reasonQ;
  logic              fvQ;

  logic [BUS_W-1:0]    busId;
  logic [DF_W-1:0]     devFn;
  logic [LVL_BITS-1:0] lvlIdx;
  logic [PFN_W-1:0]    entryPfn;
  logic [PA_W-1:0]     ctxBase;
  logic [PA_W-1:0]     ptBase;
  logic [RSN_W-1:0]    errCode;
  logic                errQuiet;
  logic                tooWide;

  assign busId    = srcQ[SID_W-1:DF_W];
  assign devFn    = srcQ[DF_W-1:0];
  assign lvlIdx   = addrQ[PAGE_SHIFT + LVL_BITS*int'(lvlQ) +: LVL_BITS];
  assign entryPfn = memData[PA_W-1:PAGE_SHIFT];
  assign ctxBase  = {ctxPtrQ, {PAGE_SHIFT{1'b0}}};
  assign ptBase   = {ptrQ, {PAGE_SHIFT{1'b0}}};
  assign tooWide  = (addrQ >> GAW) != '0;

  always_comb begin
    case (ctl.sel)
      SEL_ROOT: memAddr = rootBase + PA_W'({busId, 3'b000});
      SEL_CLO:  memAddr = ctxBase + PA_W'({devFn, 4'b0000});
      SEL_CHI:  memAddr = ctxBase + PA_W'({devFn, 4'b1000});
      default:  memAddr = ptBase + PA_W'({lvlIdx, 3'b000});
    endcase
  end

  always_comb begin
    errCode  = '0;
    errQuiet = 1'b0;
    case (ctl.sel)
      SEL_ROOT: begin
        if (!memData[0]) errCode = RSN_ROOT_ABSENT;
      end
      SEL_CLO: begin
        if (!memData[0]) begin
          errCode = RSN_CTX_ABSENT;
        end else if (memData[3:2] != 2'b00) begin
          errCode  = RSN_BAD_TYPE;
          errQuiet = memData[1];
        end
      end
      SEL_CHI: begin
        errQuiet = fpdQ;
        if (memData[2:0] != 3'(AW_CODE) || tooWide) errCode = RSN_WIDTH;
      end
      default: begin
        errQuiet = fpdQ;
        if (memData[1:0] == 2'b00)        errCode = RSN_PTE_ABSENT;
        else if (wrQ && !memData[1])      errCode = RSN_WRITE_RO;
        else if (!wrQ && !memData[0])     errCode = RSN_READ_DENIED;
      end
    endcase
  end

  assign stat.errHit    = (errCode != '0);
  assign stat.lastLevel = (lvlQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      addrQ   <= '0;
      wrQ     <= 1'b0;
      ctxPtrQ <= '0;
      ptrQ    <= '0;
      lvlQ    <= '0;
      fpdQ    <= 1'b0;
      domQ    <= '0;
      frameQ  <= '0;
      snpQ    <= 1'b0;
      faultQ  <= 1'b0;
      reasonQ <= '0;
      fvQ     <= 1'b0;
    end else begin
      fvQ <= 1'b0;
      if (ctl.ldReq) begin
        srcQ    <= reqSrcId;
        addrQ   <= reqAddr;
        wrQ     <= reqWrite;
        lvlQ    <= LVL_W'(LEVELS - 1);
        fpdQ    <= 1'b0;
        faultQ  <= 1'b0;
        reasonQ <= '0;
        snpQ    <= 1'b0;
        domQ    <= '0;
      end
      if (ctl.absorb) begin
        case (ctl.sel)
          SEL_ROOT: ctxPtrQ <= entryPfn;
          SEL_CLO: begin
            ptrQ <= entryPfn;
            fpdQ <= memData[1];
          end
          SEL_CHI: domQ <= memData[DOM_LSB +: DID_W];
          default: begin
            if (lvlQ == '0) begin
              frameQ <= entryPfn;
              snpQ   <= memData[11];
            end else begin
              ptrQ <= entryPfn;
              lvlQ <= lvlQ - 1'b1;
            end
          end
        endcase
      end
      if (ctl.commitFault) begin
        faultQ  <= 1'b1;
        reasonQ <= errCode;
        fvQ     <= !errQuiet;
      end
    end
  end

  assign rspAddr     = faultQ ? '0 : {frameQ, addrQ[PAGE_SHIFT-1:0]};
  assign rspFault    = faultQ;
  assign rspReason   = reasonQ;
  assign rspSnoop    = snpQ;
  assign rspDomain   = domQ;
  assign faultValid  = fvQ;
  assign faultReason = reasonQ;
  assign faultSrcId  = srcQ;
  assign faultAddr   = addrQ;

  AST_NO_ABSORB_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.absorb |-> !stat.errHit); // R8
  AST_FAULT_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultReason != '0); // R10
  AST_LEAF_ONLY_AT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.absorb && ctl.sel == SEL_PTE && lvlQ == '0 |=> faultQ == 1'b0); // R3
endmodule

// File: rtl/dma_remap_walker.sv
module dma_remap_walker
  import remap_pkg::*;
#(
  parameter int PA_W    = 52,
  parameter int IN_W    = 64,
  parameter int GAW     = 48,
  parameter int DID_W   = 16,
  parameter int AW_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PA_W-1:0]   rootBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [SID_W-1:0]  reqSrcId,
  input  logic [IN_W-1:0]   reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspFault,
  output logic [RSN_W-1:0]  rspReason,
  output logic              rspSnoop,
  output logic [DID_W-1:0]  rspDomain,
  output logic              faultValid,
  output logic [RSN_W-1:0]  faultReason,
  output logic [SID_W-1:0]  faultSrcId,
  output logic [IN_W-1:0]   faultAddr,
  output logic              memRd,
  output logic [PA_W-1:0]   memAddr,
  input  logic [63:0]       memData
);
  walkCtl_t  ctl;
  walkStat_t stat;

  remap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .stat     (stat),
    .ctl      (ctl)
  );

  remap_dp #(
    .PA_W    (PA_W),
    .IN_W    (IN_W),
    .GAW     (GAW),
    .DID_W   (DID_W),
    .AW_CODE (AW_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stat        (stat),
    .reqSrcId    (reqSrcId),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .rootBase    (rootBase),
    .memAddr     (memAddr),
    .memData     (memData),
    .rspAddr     (rspAddr),
    .rspFault    (rspFault),
    .rspReason   (rspReason),
    .rspSnoop    (rspSnoop),
    .rspDomain   (rspDomain),
    .faultValid  (faultValid),
    .faultReason (faultReason),
    .faultSrcId  (faultSrcId),
    .faultAddr   (faultAddr)
  );

  assign memRd = ctl.issueRd;

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memRd); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspAddr) && $stable(rspFault)
      && $stable(rspReason) && $stable(rspSnoop) && $stable(rspDomain)); // R12
  AST_FAULT_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> rspValid && rspFault); // R10
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid); // R10
  AST_OK_NO_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> !faultValid); // R3
endmodule

// File: tb/tb_dma_remap_walker.sv
module tb_dma_remap_walker;
  localparam longint unsigned ROOT_BASE = 64'h1000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [15:0]  reqSrcId = '0;
  logic [63:0]  reqAddr = '0;
  logic         reqWrite = 1'b0;
  logic         rspValid;
  logic         rspReady = 1'b0;
  logic [51:0]  rspAddr;
  logic         rspFault;
  logic [3:0]   rspReason;
  logic         rspSnoop;
  logic [15:0]  rspDomain;
  logic         faultValid;
  logic [3:0]   faultReason;
  logic [15:0]  faultSrcId;
  logic [63:0]  faultAddr;
  logic         memRd;
  logic [51:0]  memAddr;
  logic [63:0]  memData = '0;

  always #2.5 clk = ~clk;

  dma_remap_walker dut (
    .clk(clk), .rstN(rstN), .rootBase(52'(ROOT_BASE)),
    .reqValid(reqValid), .reqReady(reqReady), .reqSrcId(reqSrcId),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .rspValid(rspValid),
    .rspReady(rspReady), .rspAddr(rspAddr), .rspFault(rspFault),
    .rspReason(rspReason), .rspSnoop(rspSnoop), .rspDomain(rspDomain),
    .faultValid(faultValid), .faultReason(faultReason),
    .faultSrcId(faultSrcId), .faultAddr(faultAddr),
    .memRd(memRd), .memAddr(memAddr), .memData(memData)
  );

  logic [63:0] mem [longint unsigned];
  longint unsigned nextPg = 64'h10;
  int checks = 0;
  int errors = 0;
  int rdCnt = 0;
  int fltSeen = 0;
  logic [3:0]  fltReason;
  logic [15:0] fltSrc;
  logic [63:0] fltAddr;
  logic [51:0] cAddr;
  logic        cFault;
  logic [3:0]  cReason;
  logic        cSnoop;
  logic [15:0] cDom;
  bit          holdBad;

  function automatic logic [63:0] rdm(longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) if (memRd) memData <= rdm(longint'(memAddr));

  always @(negedge clk) begin
    if (memRd) rdCnt++;
    if (faultValid) begin
      fltSeen++;
      fltReason = faultReason;
      fltSrc    = faultSrcId;
      fltAddr   = faultAddr;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setupDev(input logic [7:0] bus, input logic [7:0] df,
                          input logic [63:0] loFlags, input logic [63:0] hi,
                          output longint unsigned pgRoot);
    longint unsigned ra = ROOT_BASE + 64'(bus) * 8;
    logic [63:0] e = rdm(ra);
    longint unsigned ct;
    if (!e[0]) begin
      ct = nextPg++;
      e = (ct << 12) | 64'd1;
      mem[ra] = e;
    end
    ct = e[51:12];
    pgRoot = nextPg++;
    mem[ct * 4096 + 64'(df) * 16]     = (pgRoot << 12) | loFlags;
    mem[ct * 4096 + 64'(df) * 16 + 8] = hi;
  endtask

  function automatic longint unsigned entryAt(longint unsigned pg, logic [63:0] iova, int lvl);
    return pg * 4096 + ((iova >> (12 + 9 * lvl)) & 64'h1FF) * 8;
  endfunction

  task automatic mapPage(input longint unsigned rootPg, input logic [63:0] iova,
                         input longint unsigned frame, input logic [63:0] leafBits);
    longint unsigned pg = rootPg;
    for (int l = 3; l >= 1; l--) begin
      longint unsigned a = entryAt(pg, iova, l);
      logic [63:0] e = rdm(a);
      if (e[1:0] == 2'b00) begin
        e = (nextPg << 12) | 64'd3;
        nextPg++;
        mem[a] = e;
      end
      pg = e[51:12];
    end
    mem[entryAt(pg, iova, 0)] = (frame << 12) | leafBits;
  endtask

  task automatic doReq(input logic [15:0] sid, input logic [63:0] addr,
                       input logic wr, input int hold);
    int wait_n = 0;
    holdBad = 1'b0;
    fltSeen = 0;
    @(negedge clk);
    reqValid = 1'b1; reqSrcId = sid; reqAddr = addr; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    rdCnt = 0;
    chk("R1 ready low during walk", 64'(reqReady), 64'd0);
    while (!rspValid && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    cAddr = rspAddr; cFault = rspFault; cReason = rspReason;
    cSnoop = rspSnoop; cDom = rspDomain;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rspValid || rspAddr !== cAddr || rspFault !== cFault ||
          rspReason !== cReason || rspDomain !== cDom) holdBad = 1'b1;
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectFault(string tag, logic [15:0] sid, logic [63:0] addr,
                             logic [3:0] rsn, bit reported);
    chk({tag, " blocked"}, 64'(cFault), 64'd1);
    chk({tag, " reason"}, 64'(cReason), 64'(rsn));
    chk({tag, " blocked addr zero"}, 64'(cAddr), 64'd0);
    chk({tag, " record count"}, 64'(fltSeen), reported ? 64'd1 : 64'd0);
    if (reported) begin
      chk({tag, " record reason"}, 64'(fltReason), 64'(rsn));
      chk({tag, " record src"}, 64'(fltSrc), 64'(sid));
      chk({tag, " record addr"}, fltAddr, addr);
    end
  endtask

  // Device layout
  localparam logic [15:0] SID_A = 16'h0510;
  localparam logic [15:0] SID_B = 16'h2231;
  localparam logic [15:0] SID_C = 16'h2240;
  localparam logic [15:0] SID_D = 16'h0511;
  localparam logic [15:0] SID_E = 16'h0512;
  localparam logic [15:0] SID_F = 16'h0513;
  localparam logic [15:0] SID_G = 16'h7700;
  localparam logic [63:0] IOVA1  = 64'h0000_7F12_3456_7ABC;
  localparam logic [63:0] IOVA2  = 64'h0000_0040_0020_1008;
  localparam logic [63:0] IOVARO = 64'h0000_1000_0000_2FF0;
  localparam logic [63:0] IOVAWO = 64'h0000_1000_0000_3010;
  localparam logic [63:0] IOVAMD = 64'h0000_2000_0040_0123;
  localparam logic [63:0] IOVAUN = 64'h0000_5555_0000_0000;
  longint unsigned pgA, pgB, pgC, pgD, pgE, pgF;

  task automatic buildTables();
    setupDev(8'h05, 8'h10, 64'h1, 64'h2 | (64'h0ABC << 8), pgA);
    mapPage(pgA, IOVA1, 64'h12345, 64'h3);
    mapPage(pgA, IOVA2, 64'hABCDE, 64'h803);
    mapPage(pgA, IOVARO, 64'h777, 64'h1);
    mapPage(pgA, IOVAWO, 64'h888, 64'h2);
    mapPage(pgA, IOVAMD, 64'h999, 64'h3);
    setupDev(8'h22, 8'h31, 64'h1, 64'h2 | (64'h0123 << 8), pgB);
    mapPage(pgB, IOVA1, 64'h54321, 64'h3);
    setupDev(8'h22, 8'h40, 64'h1, 64'h1 | (64'h0055 << 8), pgC);
    mapPage(pgC, IOVA1, 64'h11111, 64'h3);
    setupDev(8'h05, 8'h11, 64'h3, 64'h2 | (64'h0777 << 8), pgD);
    mapPage(pgD, IOVA1, 64'h22222, 64'h1);
    setupDev(8'h05, 8'h12, 64'h5, 64'h2, pgE);
    setupDev(8'h05, 8'h13, 64'h2, 64'h2, pgF);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", 64'(reqReady), 64'd1);
    chk("R12 reset rspValid", 64'(rspValid), 64'd0);
    chk("R10 reset faultValid", 64'(faultValid), 64'd0);
    chk("R1 reset memRd", 64'(memRd), 64'd0);
  endtask

  task automatic t_readOk();
    doReq(SID_A, IOVA1, 1'b0, 0);
    chk("R3 read ok fault", 64'(cFault), 64'd0);
    chk("R3 read ok addr", 64'(cAddr), {12'd0, 40'h12345, IOVA1[11:0]});
    chk("R3 read ok domain", 64'(cDom), 64'h0ABC);
    chk("R3 read ok snoop", 64'(cSnoop), 64'd0);
    chk("R2 read count", 64'(rdCnt), 64'd7);
    chk("R3 no record", 64'(fltSeen), 64'd0);
  endtask

  task automatic t_writeSnoopHold();
    doReq(SID_A, IOVA2, 1'b1, 4);
    chk("R3 write ok addr", 64'(cAddr), {12'd0, 40'hABCDE, IOVA2[11:0]});
    chk("R3 snoop hint", 64'(cSnoop), 64'd1);
    chk("R12 held while not ready", 64'(holdBad), 64'd0);
  endtask

  task automatic t_perRequester();
    doReq(SID_B, IOVA1, 1'b0, 0);
    chk("R3 other requester addr", 64'(cAddr), {12'd0, 40'h54321, IOVA1[11:0]});
    chk("R3 other requester domain", 64'(cDom), 64'h0123);
    chk("R2 other requester count", 64'(rdCnt), 64'd7);
  endtask

  task automatic t_permissions();
    doReq(SID_A, IOVARO, 1'b1, 0);
    expectFault("R9 write read-only", SID_A, IOVARO, 4'd2, 1'b1);
    doReq(SID_A, IOVARO, 1'b0, 0);
    chk("R9 read of read-only ok", 64'(cAddr), {12'd0, 40'h777, IOVARO[11:0]});
    doReq(SID_A, IOVAWO, 1'b0, 2);
    expectFault("R9 read write-only", SID_A, IOVAWO, 4'd3, 1'b1);
    chk("R12 fault held", 64'(holdBad), 64'd0);
  endtask

  task automatic t_midLevel();
    longint unsigned a3 = entryAt(pgA, IOVAMD, 3);
    longint unsigned p2 = rdm(a3) >> 12;
    longint unsigned a2 = entryAt(p2 & 64'hFF_FFFF_FFFF, IOVAMD, 2);
    logic [63:0] e2 = rdm(a2);
    mem[a2] = {e2[63:2], 2'b01};
    doReq(SID_A, IOVAMD, 1'b1, 0);
    expectFault("R9 mid-level no write", SID_A, IOVAMD, 4'd2, 1'b1);
    doReq(SID_A, IOVAMD, 1'b0, 0);
    chk("R9 mid-level read ok", 64'(cAddr), {12'd0, 40'h999, IOVAMD[11:0]});
    mem[a2] = {e2[63:2], 2'b00};
    doReq(SID_A, IOVAMD, 1'b0, 0);
    expectFault("R8 mid-level absent", SID_A, IOVAMD, 4'd1, 1'b1);
    mem[a2] = e2;
  endtask

  task automatic t_unmapped();
    doReq(SID_A, IOVAUN, 1'b0, 0);
    expectFault("R8 unmapped", SID_A, IOVAUN, 4'd1, 1'b1);
  endtask

  task automatic t_contextFaults();
    doReq(SID_F, IOVA1, 1'b0, 0);
    expectFault("R5 context absent", SID_F, IOVA1, 4'd6, 1'b1);
    chk("R5 context absent reads", 64'(rdCnt), 64'd2);
    doReq(SID_G, IOVA1, 1'b0, 0);
    expectFault("R4 root absent", SID_G, IOVA1, 4'd7, 1'b1);
    chk("R4 root absent reads", 64'(rdCnt), 64'd1);
    doReq(SID_E, IOVA1, 1'b0, 0);
    expectFault("R6 bad type", SID_E, IOVA1, 4'd4, 1'b1);
  endtask

  task automatic t_width();
    logic [63:0] wide = IOVA1 | (64'd1 << 50);
    doReq(SID_A, wide, 1'b0, 0);
    expectFault("R7 high address bit", SID_A, wide, 4'd5, 1'b1);
    doReq(SID_C, IOVA1, 1'b0, 0);
    expectFault("R7 width code", SID_C, IOVA1, 4'd5, 1'b1);
  endtask

  task automatic t_quiet();
    doReq(SID_D, IOVAUN, 1'b0, 0);
    expectFault("R11 quiet unmapped", SID_D, IOVAUN, 4'd1, 1'b0);
    doReq(SID_D, IOVA1, 1'b1, 0);
    expectFault("R11 quiet write", SID_D, IOVA1, 4'd2, 1'b0);
    doReq(SID_D, IOVA1 | (64'd1 << 48), 1'b0, 0);
    expectFault("R11 quiet width", SID_D, IOVA1 | (64'd1 << 48), 4'd5, 1'b0);
    doReq(SID_D, IOVA1, 1'b0, 0);
    chk("R11 quiet device still translates", 64'(cAddr), {12'd0, 40'h22222, IOVA1[11:0]});
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    buildTables();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readOk();
    t_writeSnoopHold();
    t_perRequester();
    t_permissions();
    t_midLevel();
    t_unmapped();
    t_contextFaults();
    t_width();
    t_quiet();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule